// File: doc/BRIEF.md
# Split-Write Programmable Phase Oscillator

This block is the numerically controlled oscillator of one correlator channel. A 32-bit phase accumulator advances by a programmable step on every sample clock edge while the channel runs. It presents the top bits of the phase and a one-cycle carry tick each time the accumulator wraps. One design serves both the carrier oscillator and the code oscillator of a channel.

The step is written from the processor clock domain as two 16-bit halves, high first and low second. The high half is only held in a staging register. The low-half write joins the two halves into one word and sends that word to the sample clock domain through a toggle-request handshake, so the sample side never sees a half-updated value. If the channel is running, the new step takes over within 175 ns of the write. If the channel is held in reset, the word waits and is applied on the first cycle after release. The processor bus decoder may drive the high-half strobe from the channel's own address and from any shared alias address.

Top module: `phase_dco`

## Requirements
- R1: After both resets the phase output is zero and the carry tick is low.
- R2: While `chanRun` is low the accumulator holds zero: `phaseMsb` reads 0 and `carryTick` stays low one sample cycle later, even if a step is written meanwhile.
- R3: On each sample edge with `chanRun` high the accumulator adds the step in use, modulo 2^32; `phaseMsb` is accumulator bits [31:24]. After k running edges from release the accumulator equals k times the step, modulo 2^32.
- R4: `carryTick` is high for the sample cycle that follows an edge whose addition wrapped past 2^32, and low otherwise.
- R5: A high-half write with no low-half write following it never changes the step in use, whether the channel is idle or running.
- R6: A step committed while the channel is idle takes effect on the first running edge after `chanRun` rises, and the step in use does not change while the channel is idle.
- R7: With the channel running, a low-half write makes the new step active no later than 175 ns after the processor edge that accepted it.
- R8: The committed step is {last high half written, low half written}: the high half fills bits [31:16] and the low half bits [15:0].
- R9: If low-half writes follow each other faster than the crossing completes, the step finally in use is the one from the last write; only one word is in flight at a time.
- R10: When `chanRun` falls, the accumulator reads zero and the carry is low on the next sample cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpuClk | input | 1 | Processor clock |
| cpuRstN | input | 1 | Active-low reset, processor domain |
| wrHiEn | input | 1 | Write strobe for the upper step half |
| wrLoEn | input | 1 | Write strobe for the lower step half (commits the word) |
| wrData | input | 16 | Write data for either half |
| smpClk | input | 1 | Sample clock |
| smpRstN | input | 1 | Active-low reset, sample domain |
| chanRun | input | 1 | High: channel active; low: channel held in reset |
| phaseMsb | output | 8 | Top bits of the phase accumulator |
| carryTick | output | 1 | One-cycle pulse after each accumulator wrap |

## Verification
The hardest state to reach is a low-half write arriving while the previous word is still crossing, because the handshake window lasts only a few cycles of each clock. The stimulus issues two full high/low pairs back to back on the processor side, so the second low write lands while the first request is unacknowledged and must be staged and then sent. The result is read from the rate of change of the phase after the crossing settles. Release timing is checked by programming while idle and then comparing every phase and carry value of the first running cycles against the exact multiples of the step.

// File: rtl/dco_pkg.sv
package dco_pkg;

  // Strobes from the sample-domain control to the accumulator datapath.
  typedef struct packed {
    logic clrAcc;   // channel held in reset: force accumulator to zero
    logic stepAcc;  // channel running: advance accumulator
    logic loadInc;  // take nextInc as the step in use on this edge
  } dcoStrb_t;

endpackage

// File: rtl/dco_wr_stage.sv
// Processor-domain side: holds the upper half, joins it with the lower
// half and launches one whole word at a time across the clock boundary.
module dco_wr_stage #(
  parameter int HALF_W = 16,
  localparam int W = 2 * HALF_W
) (
  input  logic              cpuClk,
  input  logic              cpuRstN,
  input  logic              wrHiEn,
  input  logic              wrLoEn,
  input  logic [HALF_W-1:0] wrData,
  input  logic              ackTog,
  output logic [W-1:0]      xferWord,
  output logic              reqTog,
  output logic              xferBusy
);

  logic [HALF_W-1:0] hiHold;
  logic [W-1:0]      stageWord;
  logic              stageDirty;
  logic [1:0]        ackSync;

  assign xferBusy = reqTog ^ ackSync[1];

  always_ff @(posedge cpuClk or negedge cpuRstN) begin
    if (!cpuRstN) begin
      hiHold     <= '0;
      stageWord  <= '0;
      stageDirty <= 1'b0;
      xferWord   <= '0;
      reqTog     <= 1'b0;
      ackSync    <= '0;
    end else begin
      ackSync <= {ackSync[0], ackTog};
      if (wrHiEn) begin
        hiHold <= wrData;
      end
      if (wrLoEn) begin
        if (!xferBusy) begin
          xferWord   <= {hiHold, wrData};
          reqTog     <= ~reqTog;
          stageDirty <= 1'b0;
        end else begin
          stageWord  <= {hiHold, wrData};
          stageDirty <= 1'b1;
        end
      end else if (stageDirty && !xferBusy) begin
        xferWord   <= stageWord;
        reqTog     <= ~reqTog;
        stageDirty <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dco_sync_ctrl.sv
// Sample-domain side: synchronises the request toggle, captures the word,
// decides when a new step is applied and drives the datapath strobes.
module dco_sync_ctrl
  import dco_pkg::*;
#(
  parameter int W = 32,
  parameter int SYNC_N = 2
) (
  input  logic         smpClk,
  input  logic         smpRstN,
  input  logic         chanRun,
  input  logic         reqTog,
  input  logic [W-1:0] xferWord,
  output dcoStrb_t     strb,
  output logic [W-1:0] nextInc,
  output logic         ackTog
);

  localparam int CHAIN = SYNC_N + 1;

  logic [CHAIN-1:0] reqSync;
  logic [W-1:0]     pendWord;
  logic             runQ;
  logic             arrive;

  assign arrive = reqSync[CHAIN-1] ^ reqSync[CHAIN-2];

  always_ff @(posedge smpClk or negedge smpRstN) begin
    if (!smpRstN) begin
      reqSync  <= '0;
      pendWord <= '0;
      runQ     <= 1'b0;
      ackTog   <= 1'b0;
    end else begin
      reqSync <= {reqSync[CHAIN-2:0], reqTog};
      runQ    <= chanRun;
      ackTog  <= reqSync[CHAIN-1];
      if (arrive) begin
        pendWord <= xferWord;
      end
    end
  end

  always_comb begin
    nextInc      = arrive ? xferWord : pendWord;
    strb.clrAcc  = !chanRun;
    strb.stepAcc = chanRun;
    strb.loadInc = chanRun && (arrive || !runQ);
  end

endmodule

// File: rtl/dco_datapath.sv
// Phase accumulator with the step register it advances by.
module dco_datapath
  import dco_pkg::*;
#(
  parameter int W = 32,
  parameter int PH_W = 8
) (
  input  logic            smpClk,
  input  logic            smpRstN,
  input  dcoStrb_t        strb,
  input  logic [W-1:0]    nextInc,
  output logic [W-1:0]    acc,
  output logic [W-1:0]    incInUse,
  output logic [PH_W-1:0] phaseMsb,
  output logic            carryTick
);

  logic [W-1:0] effInc;
  logic [W-1:0] sum;
  logic         ovf;

  always_comb begin
    effInc     = strb.loadInc ? nextInc : incInUse;
    {ovf, sum} = {1'b0, acc} + {1'b0, effInc};
  end

  always_ff @(posedge smpClk or negedge smpRstN) begin
    if (!smpRstN) begin
      acc       <= '0;
      incInUse  <= '0;
      carryTick <= 1'b0;
    end else begin
      if (strb.loadInc) begin
        incInUse <= nextInc;
      end
      if (strb.clrAcc) begin
        acc       <= '0;
        carryTick <= 1'b0;
      end else if (strb.stepAcc) begin
        acc       <= sum;
        carryTick <= ovf;
      end else begin
        carryTick <= 1'b0;
      end
    end
  end

  assign phaseMsb = acc[W-1 -: PH_W];

endmodule

// File: rtl/phase_dco.sv
module phase_dco
  import dco_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W = 8,
  parameter int SYNC_N = 2,
  localparam int HALF_W = ACC_W / 2
) (
  input  logic              cpuClk,
  input  logic              cpuRstN,
  input  logic              wrHiEn,
  input  logic              wrLoEn,
  input  logic [HALF_W-1:0] wrData,
  input  logic              smpClk,
  input  logic              smpRstN,
  input  logic              chanRun,
  output logic [PH_W-1:0]   phaseMsb,
  output logic              carryTick
);

  logic [ACC_W-1:0] xferWord;
  logic             reqTog;
  logic             ackTog;
  logic             xferBusy;
  dcoStrb_t         strb;
  logic [ACC_W-1:0] nextInc;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] incInUse;

  dco_wr_stage #(.HALF_W(HALF_W)) wr_i (
    .cpuClk   (cpuClk),
    .cpuRstN  (cpuRstN),
    .wrHiEn   (wrHiEn),
    .wrLoEn   (wrLoEn),
    .wrData   (wrData),
    .ackTog   (ackTog),
    .xferWord (xferWord),
    .reqTog   (reqTog),
    .xferBusy (xferBusy)
  );

  dco_sync_ctrl #(.W(ACC_W), .SYNC_N(SYNC_N)) ctrl_i (
    .smpClk   (smpClk),
    .smpRstN  (smpRstN),
    .chanRun  (chanRun),
    .reqTog   (reqTog),
    .xferWord (xferWord),
    .strb     (strb),
    .nextInc  (nextInc),
    .ackTog   (ackTog)
  );

  dco_datapath #(.W(ACC_W), .PH_W(PH_W)) dp_i (
    .smpClk    (smpClk),
    .smpRstN   (smpRstN),
    .strb      (strb),
    .nextInc   (nextInc),
    .acc       (acc),
    .incInUse  (incInUse),
    .phaseMsb  (phaseMsb),
    .carryTick (carryTick)
  );

endmodule

// File: rtl/dco_checker.sv
module dco_checker #(
  parameter int W = 32,
  parameter int PH_W = 8
) (
  input logic            smpClk,
  input logic            smpRstN,
  input logic            cpuClk,
  input logic            cpuRstN,
  input logic            chanRun,
  input logic [PH_W-1:0] phaseMsb,
  input logic            carryTick,
  input logic            loadInc,
  input logic [W-1:0]    acc,
  input logic [W-1:0]    incInUse,
  input logic            xferBusy,
  input logic            reqTog,
  input logic [W-1:0]    xferWord
);

  // R2 / R10: idle channel reads zero with no carry on the next cycle
  p_idle_zero_r2: assert property (@(posedge smpClk) disable iff (!smpRstN)
    !chanRun |=> (phaseMsb == '0 && !carryTick));

  // R3: running without a new step, the accumulator advances by the step in use
  p_step_r3: assert property (@(posedge smpClk) disable iff (!smpRstN)
    (chanRun && !loadInc) |=> (acc == $past(acc) + $past(incInUse)));

  // R4: a carry is only reported after a wrap while running
  p_carry_wrap_r4: assert property (@(posedge smpClk) disable iff (!smpRstN)
    carryTick |-> ($past(chanRun) && acc < $past(acc)));

  // R6: the step in use never changes while the channel is idle
  p_hold_idle_r6: assert property (@(posedge smpClk) disable iff (!smpRstN)
    !chanRun |=> $stable(incInUse));

  // R7: the word in flight is held still until acknowledged
  p_busy_hold_r7: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    xferBusy |=> $stable(xferWord));

  // R9: a new request is only launched when none is outstanding
  p_one_in_flight_r9: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    (reqTog != $past(reqTog)) |-> !$past(xferBusy));

endmodule

bind phase_dco dco_checker #(.W(ACC_W), .PH_W(PH_W)) chk_i (
  .smpClk    (smpClk),
  .smpRstN   (smpRstN),
  .cpuClk    (cpuClk),
  .cpuRstN   (cpuRstN),
  .chanRun   (chanRun),
  .phaseMsb  (phaseMsb),
  .carryTick (carryTick),
  .loadInc   (strb.loadInc),
  .acc       (acc),
  .incInUse  (incInUse),
  .xferBusy  (xferBusy),
  .reqTog    (reqTog),
  .xferWord  (xferWord)
);

// File: tb/phase_dco_tb_top.sv
`timescale 1ns/1ps
module phase_dco_tb_top;

  logic        cpuClk = 1'b0;
  logic        smpClk = 1'b0;
  logic        cpuRstN = 1'b0;
  logic        smpRstN = 1'b0;
  logic        wrHiEn = 1'b0;
  logic        wrLoEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        chanRun = 1'b0;
  logic [7:0]  phaseMsb;
  logic        carryTick;

  int unsigned checkCount = 0;
  int unsigned failCount = 0;
  int unsigned smpCount = 0;

  typedef struct {
    int unsigned at;
    logic [7:0]  ph;
    logic        cy;
    string       tag;
  } item_t;

  item_t sbQ[$];

  always #2.5 smpClk = ~smpClk;   // 200 MHz sample clock
  always #3.5 cpuClk = ~cpuClk;   // unrelated processor clock

  always @(posedge smpClk) smpCount <= smpCount + 1;

  phase_dco dut_i (
    .cpuClk    (cpuClk),
    .cpuRstN   (cpuRstN),
    .wrHiEn    (wrHiEn),
    .wrLoEn    (wrLoEn),
    .wrData    (wrData),
    .smpClk    (smpClk),
    .smpRstN   (smpRstN),
    .chanRun   (chanRun),
    .phaseMsb  (phaseMsb),
    .carryTick (carryTick)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checkCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Monitor: compares scoreboard items in the cycle they fall due.
  always @(negedge smpClk) begin
    item_t it;
    if (sbQ.size() > 0 && sbQ[0].at <= smpCount) begin
      it = sbQ.pop_front();
      if (it.at != smpCount) begin
        check({it.tag, " missed"}, smpCount, it.at);
      end else begin
        check({it.tag, " phase"}, 32'(phaseMsb), 32'(it.ph));
        check({it.tag, " carry"}, 32'(carryTick), 32'(it.cy));
      end
    end
  end

  task automatic cpuWrite(input bit hi, input logic [15:0] d);
    @(negedge cpuClk);
    wrHiEn = hi;
    wrLoEn = !hi;
    wrData = d;
    @(negedge cpuClk);
    wrHiEn = 1'b0;
    wrLoEn = 1'b0;
  endtask

  task automatic progWord(input logic [31:0] w);
    cpuWrite(1'b1, w[31:16]);
    cpuWrite(1'b0, w[15:0]);
  endtask

  // Driver: releases the channel and queues the exact expected phase
  // and carry for each of the first n running edges.
  task automatic releaseSweep(input logic [31:0] inc, input int n, input string tag);
    int unsigned c0;
    @(negedge smpClk);
    chanRun = 1'b1;
    c0 = smpCount;
    for (int k = 1; k <= n; k++) begin
      item_t it;
      longint unsigned cur;
      longint unsigned prv;
      cur = longint'(k) * longint'(inc);
      prv = longint'(k - 1) * longint'(inc);
      it.at  = c0 + k;
      it.ph  = cur[31:24];
      it.cy  = (cur[63:32] != prv[63:32]);
      it.tag = tag;
      sbQ.push_back(it);
    end
    repeat (n + 2) @(negedge smpClk);
    check({tag, " queue drained"}, sbQ.size(), 0);
  endtask

  task automatic stopChan(input string tag);
    @(negedge smpClk);
    chanRun = 1'b0;
    @(negedge smpClk);
    check({tag, " phase"}, 32'(phaseMsb), 0);
    check({tag, " carry"}, 32'(carryTick), 0);
  endtask

  task automatic measureDelta(input logic [7:0] exp, input string tag);
    logic [7:0] p0;
    @(negedge smpClk);
    p0 = phaseMsb;
    @(negedge smpClk);
    check(tag, 32'(phaseMsb - p0), 32'(exp));
  endtask

  initial begin
    #1_000_000;
    checkCount++;
    failCount++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (6) @(negedge smpClk);
    cpuRstN = 1'b1;
    smpRstN = 1'b1;
    repeat (3) @(negedge smpClk);

    // R1: reset state
    check("R1 phase", 32'(phaseMsb), 0);
    check("R1 carry", 32'(carryTick), 0);

    // R2: idle channel ignores a committed step
    progWord(32'h2000_0000);
    repeat (20) @(negedge smpClk);
    check("R2 phase idle", 32'(phaseMsb), 0);
    check("R2 carry idle", 32'(carryTick), 0);

    // R3, R4, R6: release applies the idle-committed step; wraps at k=8,16
    releaseSweep(32'h2000_0000, 17, "R3/R4/R6 sweep");
    stopChan("R10 after sweep");

    // R8: both halves land in their own fields
    progWord(32'h0123_4567);
    repeat (20) @(negedge smpClk);
    releaseSweep(32'h0123_4567, 12, "R8 halves");
    stopChan("R10 second stop");

    // R5: upper-half write alone while idle leaves the step unchanged
    cpuWrite(1'b1, 16'h7000);
    repeat (20) @(negedge smpClk);
    releaseSweep(32'h0123_4567, 6, "R5 idle hi-only");
    stopChan("R10 third stop");

    // R7: running channel picks up a low-half write within 175 ns
    progWord(32'h2000_0000);
    repeat (20) @(negedge smpClk);
    @(negedge smpClk);
    chanRun = 1'b1;
    repeat (3) @(negedge smpClk);
    measureDelta(8'd32, "R3 running rate");
    cpuWrite(1'b1, 16'h0100);
    repeat (60) @(negedge smpClk);
    measureDelta(8'd32, "R5 running hi-only");
    cpuWrite(1'b0, 16'h0000);
    #172;
    measureDelta(8'd1, "R7 new step within bound");
    check("R7 no carry", 32'(carryTick), 0);

    // R9: second pair arrives while the first word is still crossing
    progWord(32'h0200_0000);
    progWord(32'h0600_0000);
    repeat (100) @(negedge smpClk);
    measureDelta(8'd6, "R9 last write wins");
    stopChan("R10 final stop");

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule